// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a watchdog peripheral behind a small 32-bit register bus. Software first loads a down-counting timer and then selects what should happen when the timer runs out. The choices are nothing, a general-purpose interrupt pulse, a non-maskable interrupt pulse, or a request to reset the whole chip. Software keeps the system alive by writing the timer register again before the count reaches zero. A write to the timer takes effect only after a fixed number of clocks, which models the internal settle time of the reload path.

A sticky status bit records that the most recent chip reset came from the watchdog. This bit is cleared only by a separate power-on reset input. It therefore survives the ordinary reset that the watchdog itself requests, and software can read it after reboot to learn why the chip restarted.

Top module: `wdog_timer`

## Requirements
- R1: After reset both registers read zero and all three expiry outputs are low.
- R2: The control register sits at byte offset 0x00 and the timer at 0x04. A control read returns the action field in bits [1:0], the watchdog-reset flag in bit 31, and zero in all other bits. A timer read returns the live count. Any other offset reads as zero.
- R3: A timer write commits the written value to the count exactly COMMIT_DLY clock edges after the edge that samples the write. Until then, reads return the old count.
- R4: With action field 0, the count holds its value.
- R5: With a nonzero action field, the count drops by one on every clock and stays at zero once it gets there.
- R6: When the count is zero and the action field is nonzero, exactly one output pulses high for exactly one cycle, on the edge after the count reached zero. Action 1 drives `irq_o`, action 2 drives `nmi_o`, and action 3 drives `chip_rst_req_o`.
- R7: After firing, the block stays silent until a timer reload commits. A committed reload arms it again.
- R8: The watchdog-reset flag is set on the same edge that raises `chip_rst_req_o`. It survives `rst_n`, and only `por_n` clears it. Bus writes to bit 31 have no effect.
- R9: With action field 0, no expiry output ever goes high, even when the count is zero.
- R10: A second timer write that arrives while an earlier one is still pending replaces the pending value and restarts the commit delay. The earlier value never reaches the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low chip reset, asynchronous; leaves the flag intact |
| por_n | input | 1 | Active-low power-on reset, asynchronous; clears everything |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | One-cycle general-purpose interrupt pulse |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse |
| chip_rst_req_o | output | 1 | One-cycle full-chip reset request |

## Verification
The bench builds the block with a full 32-bit counter and a commit delay of three cycles. Three cycles is enough room to land a second timer write inside the pending window, which exercises the replacement rule. Random loads are kept to a few dozen counts so that every expiry action can be reached many times. One directed load of all ones checks that the full counter width reads back and decrements without waiting for it to expire. The bench plays the reset controller: after each reset request it pulses `rst_n` and then `por_n`, so the persistence and clearing of the flag are both observed.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W      = 32,
  parameter int COMMIT_DLY = 3,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              chip_rst_req_o
);
  localparam int PW = $clog2(COMMIT_DLY + 1);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] TMR_OFS  = ADDR_W'(4);
  localparam logic [PW-1:0]     DLY_LD   = PW'(COMMIT_DLY);
  localparam logic [PW-1:0]     DLY_ONE  = PW'(1);

  logic             sys_rst_n;
  logic [1:0]       act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pend_q;
  logic [PW-1:0]    pcnt_q;
  logic             fired_q;
  logic             wd_flag_q;
  logic             ctrl_we, tmr_we, commit, expire;

  assign sys_rst_n = rst_n & por_n;
  assign ctrl_we   = bus_we && (bus_addr == CTRL_OFS);
  assign tmr_we    = bus_we && (bus_addr == TMR_OFS);
  assign commit    = (pcnt_q == DLY_ONE) && !tmr_we;
  assign expire    = (act_q != 2'd0) && (cnt_q == '0) && !fired_q && !commit;

  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n)   act_q <= 2'd0;
    else if (ctrl_we) act_q <= bus_wdata[1:0];

  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      pend_q <= '0;
      pcnt_q <= '0;
    end else if (tmr_we) begin
      pend_q <= bus_wdata[CNT_W-1:0];
      pcnt_q <= DLY_LD;
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - DLY_ONE;
    end

  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (commit) begin
      cnt_q   <= pend_q;
      fired_q <= 1'b0;
    end else begin
      if (act_q != 2'd0 && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (expire) fired_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      irq_o          <= 1'b0;
      nmi_o          <= 1'b0;
      chip_rst_req_o <= 1'b0;
    end else begin
      irq_o          <= expire && act_q == 2'd1;
      nmi_o          <= expire && act_q == 2'd2;
      chip_rst_req_o <= expire && act_q == 2'd3;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                         wd_flag_q <= 1'b0;
    else if (expire && act_q == 2'd3)   wd_flag_q <= 1'b1;

  always_comb
    case (bus_addr)
      CTRL_OFS: bus_rdata = {wd_flag_q, 29'd0, act_q};
      TMR_OFS:  bus_rdata = 32'(cnt_q);
      default:  bus_rdata = 32'd0;
    endcase

  // R6: at most one output at a time, and never two cycles in a row
  a_r6_onehot: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $onehot0({irq_o, nmi_o, chip_rst_req_o}));
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (irq_o || nmi_o || chip_rst_req_o) |=> !(irq_o || nmi_o || chip_rst_req_o));

  // R3: a commit loads the value held while pending
  a_r3_commit: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pcnt_q == DLY_ONE && !tmr_we) |=> cnt_q == $past(pend_q));

  // R4 and R5: count holds when idle and steps down by one when armed
  a_r4_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (act_q == 2'd0 && pcnt_q != DLY_ONE) |=> $stable(cnt_q));
  a_r5_step: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (act_q != 2'd0 && cnt_q != '0 && pcnt_q != DLY_ONE) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R9: no output follows a cycle with the action field at zero
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (act_q == 2'd0) |=> !(irq_o || nmi_o || chip_rst_req_o));

  // R8: flag accompanies a reset request and stays until power-on reset
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!sys_rst_n)
    chip_rst_req_o |-> wd_flag_q);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    wd_flag_q |=> wd_flag_q);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int DLY = 3;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_TMR  = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, nmi_o, chip_rst_req_o;

  int checks = 0, errors = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_timer #(.CNT_W(32), .COMMIT_DLY(DLY), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .nmi_o(nmi_o), .chip_rst_req_o(chip_rst_req_o));

  function automatic int fire_idx(input int n);
    return n + 1;
  endfunction
  function automatic int reload_fire_idx(input int n);
    return DLY + n + 1;
  endfunction
  function automatic logic [31:0] ctrl_val(input bit flag, input logic [1:0] a);
    return {flag, 29'd0, a};
  endfunction
  function automatic logic [2:0] pulse_vec(input logic [1:0] a);
    return (a == 2'd1) ? 3'b100 : (a == 2'd2) ? 3'b010 : (a == 2'd3) ? 3'b001 : 3'b000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_chip_reset();
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(A_CTRL, v); chk("R8 flag after chip reset", v, ctrl_val(exp_flag, 2'd0));
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, v); chk("R8 flag after write of zero", v, ctrl_val(exp_flag, 2'd0));
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    exp_flag = 1'b0;
    rd(A_CTRL, v); chk("R8 flag cleared by power-on reset", v, 32'd0);
  endtask

  task automatic expiry_trial(input int n, input logic [1:0] a);
    logic [31:0] v;
    int sel_hits, sel_k, other_hits;
    logic [2:0] want, got;
    want = pulse_vec(a);
    wr(A_CTRL, 32'd0);
    wr(A_TMR, n);
    repeat (DLY) @(negedge clk);
    wr(A_CTRL, {30'd0, a});
    rd(A_TMR, v); chk("R3 loaded count", v, n);
    sel_hits = 0; sel_k = -1; other_hits = 0;
    for (int k = 1; k <= n + 6; k++) begin
      @(negedge clk);
      got = {irq_o, nmi_o, chip_rst_req_o};
      if ((got & want) != 0) begin sel_hits++; sel_k = k; end
      if ((got & ~want) != 0) other_hits++;
      if (k == n / 2 && k >= 1) begin
        rd(A_TMR, v); chk("R5 mid-count", v, n - k);
      end
    end
    chk("R6 selected output pulses once", sel_hits, 1);
    chk("R6 pulse cycle", sel_k, fire_idx(n));
    chk("R6 other outputs quiet", other_hits, 0);
    rd(A_TMR, v); chk("R5 count stays at zero", v, 0);
    if (a == 2'd3) begin
      exp_flag = 1'b1;
      rd(A_CTRL, v); chk("R8 flag set on request", v, ctrl_val(1'b1, 2'd3));
      do_chip_reset();
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    checks++; errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int r, hits, kk;
    logic [2:0] got;
    r = $urandom(32'd20250611);

    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    rd(A_CTRL, v); chk("R1 control after reset", v, 32'd0);
    rd(A_TMR, v);  chk("R1 timer after reset", v, 32'd0);
    chk("R1 outputs after reset", {29'd0, irq_o, nmi_o, chip_rst_req_o}, 32'd0);
    rd(8'h08, v);  chk("R2 unmapped offset", v, 32'd0);

    // R9: idle with count zero, no pulse
    hits = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq_o || nmi_o || chip_rst_req_o) hits++;
    end
    chk("R9 no output with action zero", hits, 0);

    // R3: commit timing, R4: hold with action zero
    wr(A_TMR, 32'd123);
    repeat (DLY - 1) @(negedge clk);
    rd(A_TMR, v); chk("R3 old count before commit", v, 0);
    @(negedge clk);
    rd(A_TMR, v); chk("R3 new count at commit", v, 123);
    repeat (10) @(negedge clk);
    rd(A_TMR, v); chk("R4 count holds", v, 123);

    // R2 and R8: bit 31 write ignored, other bits read zero
    wr(A_CTRL, 32'hFFFF_FFF0);
    rd(A_CTRL, v); chk("R8 bit 31 write ignored", v, ctrl_val(1'b0, 2'd0));
    wr(A_CTRL, 32'h8000_0001);
    rd(A_CTRL, v); chk("R2 control layout", v, ctrl_val(1'b0, 2'd1));
    wr(A_CTRL, 32'd0);

    // R5: full-width load decrements
    wr(A_TMR, 32'hFFFF_FFFF);
    repeat (DLY) @(negedge clk);
    rd(A_TMR, v); chk("R2 full-width read", v, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'd2);
    repeat (5) @(negedge clk);
    rd(A_TMR, v); chk("R5 full-width decrement", v, 32'hFFFF_FFFA);
    wr(A_CTRL, 32'd0);

    // R10: second write replaces pending value
    wr(A_TMR, 32'd9);
    repeat (DLY) @(negedge clk);
    wr(A_TMR, 32'd50);
    wr(A_TMR, 32'd7);
    for (int k = 0; k < DLY; k++) begin
      rd(A_TMR, v); chk("R10 pending value not committed", v, 9);
      @(negedge clk);
    end
    rd(A_TMR, v); chk("R10 replacement committed", v, 7);

    // R7: no refire until reload, then re-arm
    expiry_trial(4, 2'd1);
    hits = 0;
    repeat (8) begin
      @(negedge clk);
      if (irq_o) hits++;
    end
    chk("R7 no refire without reload", hits, 0);
    wr(A_TMR, 32'd5);
    hits = 0; kk = -1;
    for (int k = 1; k <= DLY + 12; k++) begin
      @(negedge clk);
      got = {irq_o, nmi_o, chip_rst_req_o};
      if (got != 3'b000) begin hits++; kk = k; end
    end
    chk("R7 reload re-arms once", hits, 1);
    chk("R7 re-armed pulse cycle", kk, reload_fire_idx(5));

    // R6: directed chip reset then random mix
    expiry_trial(1, 2'd3);
    for (int t = 0; t < 24; t++) begin
      int n;
      logic [1:0] a;
      n = 1 + ($urandom % 30);
      a = 2'(1 + ($urandom % 3));
      expiry_trial(n, a);
    end

    finish_run();
  end
endmodule